// File: doc/BRIEF.md
# Tag-Only Issue Queue with Branch-Dependency Masks

This block is a shared out-of-order issue queue that sits between rename/dispatch and a single functional-unit port. Each slot holds an instruction's physical source tags, its physical destination tag, its reorder-buffer index and a mask of the unresolved branches it depends on. Operand data stays in the shared register file and never enters the queue. Each source also has a ready flag, which is the slot's own copy of the global busy state.

Dispatch writes one instruction per cycle into the lowest free slot. The ready flags start from the busy inputs and are then set by a single wakeup tag broadcast each cycle. Each cycle the queue offers the oldest slot whose sources are all ready to the functional-unit port and frees that slot at the clock edge. A branch outcome either clears its mask bit in every slot (correct prediction) or removes every slot that carries that bit (mispredict), in one cycle.

Top module: `iq_top`

## Requirements
- R1: After synchronous reset the queue is empty: `full` is 0 and `iss_valid` is 0.
- R2: An instruction is accepted when `disp_valid` is 1 and `full` is 0. It can be issued from the cycle after dispatch at the earliest, never in its dispatch cycle.
- R3: At dispatch, source s is recorded as ready when `disp_busy[s]` is 0 (bit s of `disp_busy` belongs to `disp_src[s]`, and 1 means busy), or when `wake_valid` is 1 and `wake_tag` equals that source tag in the same cycle.
- R4: When `wake_valid` is 1, every queued source whose tag equals `wake_tag` becomes ready at that clock edge. An instruction whose last source was woken can issue in the following cycle.
- R5: Each cycle, the valid entry with all sources ready that was dispatched earliest is presented on the issue outputs: sources, destination, reorder index and mask. At most one entry is presented, and it is freed at the clock edge. A slot that is reused counts as younger than every entry already queued.
- R6: When `br_valid` is 1 and `br_bad` is 0, bit `br_idx` of the mask is cleared in every queued entry and in an instruction dispatched in the same cycle. An entry issued in that cycle shows the bit already cleared on `iss_bmask`.
- R7: When `br_valid` is 1 and `br_bad` is 1, every queued entry with mask bit `br_idx` set is removed at that clock edge. An instruction dispatched in the same cycle with that bit set is dropped, and an affected entry is not issued in that cycle.
- R8: `full` is 1 exactly when every slot is occupied. A dispatch while `full` is 1 is discarded, even if an issue frees a slot in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_src | input | NSRC*PTAG_W | Physical source tags |
| disp_busy | input | NSRC | Busy flag per source (1 = not yet produced) |
| disp_dst | input | PTAG_W | Physical destination tag |
| disp_rob | input | ROB_W | Reorder-buffer index |
| disp_bmask | input | BR_N | Unresolved branches the instruction depends on |
| full | output | 1 | All slots occupied, dispatch refused |
| wake_valid | input | 1 | Wakeup broadcast present |
| wake_tag | input | PTAG_W | Destination tag of a completing instruction |
| br_valid | input | 1 | Branch outcome present |
| br_bad | input | 1 | 1 = mispredicted, 0 = correctly predicted |
| br_idx | input | log2(BR_N) | Branch tag that resolved |
| iss_valid | output | 1 | An entry is issued this cycle |
| iss_src | output | NSRC*PTAG_W | Source tags of the issued entry |
| iss_dst | output | PTAG_W | Destination tag of the issued entry |
| iss_rob | output | ROB_W | Reorder index of the issued entry |
| iss_bmask | output | BR_N | Branch mask of the issued entry |

## Verification
The bench builds the queue with four slots, two branch tags, 4-bit physical tags and 4-bit reorder indices. This makes a full queue, a refused dispatch and slot reuse reachable within a few cycles. It sweeps every combination of the two busy flags against no wakeup, a wakeup of either source at dispatch and wakeups afterwards. For each branch tag it covers both outcomes against all four mask values, and it checks the issue order against the dispatch order, including after a freed slot has been reused.

// File: rtl/iq_pkg.sv
package iq_pkg;

    typedef enum logic [1:0] {
        BR_IDLE    = 2'd0,
        BR_CONFIRM = 2'd1,
        BR_KILL    = 2'd2
    } br_act_e;

    function automatic br_act_e br_decode(input logic vld, input logic bad);
        if (!vld)
            return BR_IDLE;
        return bad ? BR_KILL : BR_CONFIRM;
    endfunction

endpackage

// File: rtl/iq_alloc.sv
module iq_alloc #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  free_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        any_o = |free_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_i[i])
                idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/iq_age_select.sv
module iq_age_select #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc_en,
    input  logic [IW-1:0] alloc_idx,
    input  logic [N-1:0]  valid_i,
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  grant_o,
    output logic [IW-1:0] gidx_o
);
    // older_q[i][j] = 1 : entry i was dispatched before entry j
    logic [N-1:0] older_q [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++)
                older_q[i] <= '0;
        end else if (alloc_en) begin
            for (int j = 0; j < N; j++) begin
                older_q[alloc_idx][j] <= 1'b0;
                older_q[j][alloc_idx] <= valid_i[j];
            end
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_col
        logic [N-1:0] col;
        always_comb begin
            for (int j = 0; j < N; j++)
                col[j] = older_q[j][i];
        end
        assign grant_o[i] = req_i[i] & ~|(req_i & col);
    end

    always_comb begin
        gidx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (grant_o[i])
                gidx_o = IW'(i);
        end
    end
endmodule

// File: rtl/iq_top.sv
module iq_top
    import iq_pkg::*;
#(
    parameter  int ENTRIES = 16,
    parameter  int NSRC    = 2,
    parameter  int PTAG_W  = 6,
    parameter  int ROB_W   = 5,
    parameter  int BR_N    = 4,
    localparam int IW      = $clog2(ENTRIES),
    localparam int BIDX_W  = $clog2(BR_N)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        disp_valid,
    input  logic [NSRC-1:0][PTAG_W-1:0] disp_src,
    input  logic [NSRC-1:0]             disp_busy,
    input  logic [PTAG_W-1:0]           disp_dst,
    input  logic [ROB_W-1:0]            disp_rob,
    input  logic [BR_N-1:0]             disp_bmask,
    output logic                        full,
    input  logic                        wake_valid,
    input  logic [PTAG_W-1:0]           wake_tag,
    input  logic                        br_valid,
    input  logic                        br_bad,
    input  logic [BIDX_W-1:0]           br_idx,
    output logic                        iss_valid,
    output logic [NSRC-1:0][PTAG_W-1:0] iss_src,
    output logic [PTAG_W-1:0]           iss_dst,
    output logic [ROB_W-1:0]            iss_rob,
    output logic [BR_N-1:0]             iss_bmask
);
    typedef struct packed {
        logic [NSRC-1:0][PTAG_W-1:0] src;
        logic [NSRC-1:0]             rdy;
        logic [PTAG_W-1:0]           dst;
        logic [ROB_W-1:0]            rob;
        logic [BR_N-1:0]             bmask;
    } slot_t;

    slot_t                 slot_q [ENTRIES];
    logic [ENTRIES-1:0]    valid_q;
    logic [BR_N-1:0]       mask_vec [ENTRIES];
    logic [ENTRIES-1:0]    kill, req, grant;
    logic [IW-1:0]         gidx, aidx;
    logic                  any_free, disp_do, disp_kill;
    br_act_e               br_act;
    logic [BR_N-1:0]       br_hot, clr_mask;
    slot_t                 new_slot;

    assign br_act   = br_decode(br_valid, br_bad);
    assign br_hot   = BR_N'(1) << br_idx;
    assign clr_mask = (br_act == BR_CONFIRM) ? br_hot : '0;
    assign full     = &valid_q;

    // per-slot kill, request and wakeup match
    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic [NSRC-1:0] hit;
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            assign hit[s] = wake_valid && (slot_q[i].src[s] == wake_tag);
        end
        assign kill[i]     = (br_act == BR_KILL) && |(slot_q[i].bmask & br_hot);
        assign req[i]      = valid_q[i] && (&slot_q[i].rdy) && !kill[i];
        assign mask_vec[i] = slot_q[i].bmask;

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[i] <= 1'b0;
            end else if (disp_do && (aidx == IW'(i))) begin
                valid_q[i] <= 1'b1;
                slot_q[i]  <= new_slot;
            end else begin
                if (kill[i] || grant[i])
                    valid_q[i] <= 1'b0;
                slot_q[i].rdy   <= slot_q[i].rdy | hit;
                slot_q[i].bmask <= slot_q[i].bmask & ~clr_mask;
            end
        end
    end

    // incoming instruction
    assign disp_kill = (br_act == BR_KILL) && |(disp_bmask & br_hot);
    assign disp_do   = disp_valid && any_free && !disp_kill;

    always_comb begin
        new_slot.src   = disp_src;
        new_slot.dst   = disp_dst;
        new_slot.rob   = disp_rob;
        new_slot.bmask = disp_bmask & ~clr_mask;
        for (int s = 0; s < NSRC; s++)
            new_slot.rdy[s] = !disp_busy[s] || (wake_valid && (disp_src[s] == wake_tag));
    end

    iq_alloc #(.N(ENTRIES), .IW(IW)) u_alloc (
        .free_i (~valid_q),
        .any_o  (any_free),
        .idx_o  (aidx)
    );

    iq_age_select #(.N(ENTRIES), .IW(IW)) u_age (
        .clk       (clk),
        .rst       (rst),
        .alloc_en  (disp_do),
        .alloc_idx (aidx),
        .valid_i   (valid_q),
        .req_i     (req),
        .grant_o   (grant),
        .gidx_o    (gidx)
    );

    assign iss_valid = |grant;
    assign iss_src   = slot_q[gidx].src;
    assign iss_dst   = slot_q[gidx].dst;
    assign iss_rob   = slot_q[gidx].rob;
    assign iss_bmask = slot_q[gidx].bmask & ~clr_mask;

endmodule

// File: rtl/iq_top_chk.sv
module iq_top_chk #(
    parameter  int ENTRIES = 16,
    parameter  int BR_N    = 4,
    localparam int BIDX_W  = $clog2(BR_N)
) (
    input logic               clk,
    input logic               rst,
    input logic [ENTRIES-1:0] valid_q,
    input logic [BR_N-1:0]    mask_vec [ENTRIES],
    input logic [ENTRIES-1:0] grant,
    input logic               iss_valid,
    input logic               full,
    input logic               disp_valid,
    input logic               br_valid,
    input logic [BIDX_W-1:0]  br_idx
);
    logic [BR_N-1:0] col_any;
    always_comb begin
        col_any = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (valid_q[i])
                col_any = col_any | mask_vec[i];
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R5

    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (valid_q == '0) |-> !iss_valid); // R5

    AST_ISSUE_FREES: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !disp_valid && !br_valid)
        |=> ($countones(valid_q) == $past($countones(valid_q)) - 1)); // R5

    AST_DISP_GROWS: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && !full && !iss_valid && !br_valid)
        |=> ($countones(valid_q) == $past($countones(valid_q)) + 1)); // R2

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (full && !iss_valid && !br_valid) |=> full); // R8

    AST_BR_BIT_GONE: assert property (@(posedge clk) disable iff (rst)
        br_valid |=> !col_any[$past(br_idx)]); // R6 R7

endmodule

bind iq_top iq_top_chk #(.ENTRIES(ENTRIES), .BR_N(BR_N)) u_iq_chk (
    .clk        (clk),
    .rst        (rst),
    .valid_q    (valid_q),
    .mask_vec   (mask_vec),
    .grant      (grant),
    .iss_valid  (iss_valid),
    .full       (full),
    .disp_valid (disp_valid),
    .br_valid   (br_valid),
    .br_idx     (br_idx)
);

// File: tb/test_iq_top.sv
module test_iq_top;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES = 4;
    localparam int NSRC    = 2;
    localparam int PTAG_W  = 4;
    localparam int ROB_W   = 4;
    localparam int BR_N    = 2;
    localparam int BIDX_W  = $clog2(BR_N);

    logic                        clk = 1'b0;
    logic                        rst;
    logic                        disp_valid;
    logic [NSRC-1:0][PTAG_W-1:0] disp_src;
    logic [NSRC-1:0]             disp_busy;
    logic [PTAG_W-1:0]           disp_dst;
    logic [ROB_W-1:0]            disp_rob;
    logic [BR_N-1:0]             disp_bmask;
    logic                        full;
    logic                        wake_valid;
    logic [PTAG_W-1:0]           wake_tag;
    logic                        br_valid;
    logic                        br_bad;
    logic [BIDX_W-1:0]           br_idx;
    logic                        iss_valid;
    logic [NSRC-1:0][PTAG_W-1:0] iss_src;
    logic [PTAG_W-1:0]           iss_dst;
    logic [ROB_W-1:0]            iss_rob;
    logic [BR_N-1:0]             iss_bmask;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    iq_top #(.ENTRIES(ENTRIES), .NSRC(NSRC), .PTAG_W(PTAG_W), .ROB_W(ROB_W), .BR_N(BR_N)) i_iq_top (
        .clk(clk), .rst(rst),
        .disp_valid(disp_valid), .disp_src(disp_src), .disp_busy(disp_busy),
        .disp_dst(disp_dst), .disp_rob(disp_rob), .disp_bmask(disp_bmask), .full(full),
        .wake_valid(wake_valid), .wake_tag(wake_tag),
        .br_valid(br_valid), .br_bad(br_bad), .br_idx(br_idx),
        .iss_valid(iss_valid), .iss_src(iss_src), .iss_dst(iss_dst),
        .iss_rob(iss_rob), .iss_bmask(iss_bmask)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // advance to the next cycle and return all inputs to idle
    task automatic nxt();
        @(posedge clk);
        #1;
        disp_valid = 0; disp_src = '0; disp_busy = '0; disp_dst = '0;
        disp_rob = '0; disp_bmask = '0; wake_valid = 0; wake_tag = '0;
        br_valid = 0; br_bad = 0; br_idx = '0;
    endtask

    task automatic disp(input int rob, input int s0, input int s1, input int busy, input int bm);
        disp_valid = 1;
        disp_src[0] = PTAG_W'(s0);
        disp_src[1] = PTAG_W'(s1);
        disp_busy   = NSRC'(busy);
        disp_dst    = PTAG_W'(rob + 1);
        disp_rob    = ROB_W'(rob);
        disp_bmask  = BR_N'(bm);
    endtask

    task automatic wake(input int tag);
        wake_valid = 1;
        wake_tag   = PTAG_W'(tag);
    endtask

    task automatic expect_issue(input string req, input int rob, input int bm);
        #1;
        check(req, "iss_valid", int'(iss_valid), 1);
        check(req, "iss_rob", int'(iss_rob), rob);
        check(req, "iss_bmask", int'(iss_bmask), bm);
    endtask

    task automatic expect_none(input string req);
        #1;
        check(req, "iss_valid idle", int'(iss_valid), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1;
        nxt();
        rst = 1;
        nxt();
        rst = 0;
        // R1 reset state
        #1;
        check("R1", "full", int'(full), 0);
        check("R1", "iss_valid", int'(iss_valid), 0);

        // R2: not issuable in dispatch cycle, issuable next cycle, then freed
        nxt(); disp(1, 2, 3, 0, 0);
        expect_none("R2");
        nxt(); expect_issue("R2", 1, 0);
        check("R5", "iss_dst", int'(iss_dst), 2);
        check("R5", "iss_src0", int'(iss_src[0]), 2);
        check("R5", "iss_src1", int'(iss_src[1]), 3);
        nxt(); expect_none("R5");

        // R3 / R4: busy flags against wakeups at and after dispatch
        for (int b = 0; b < 4; b++) begin
            for (int w = 0; w < 3; w++) begin
                bit r0, r1;
                nxt(); disp(b * 3 + w, 3, 5, b, 0);
                if (w == 1) wake(3);
                if (w == 2) wake(5);
                r0 = !b[0] || (w == 1);
                r1 = !b[1] || (w == 2);
                nxt(); #1;
                check("R3", "ready after dispatch", int'(iss_valid), int'(r0 && r1));
                if (r0 && r1) begin
                    check("R3", "rob", int'(iss_rob), b * 3 + w);
                end else begin
                    nxt(); wake(3);
                    expect_none("R4");
                    nxt(); wake(5); #1;
                    check("R4", "after src0 wake", int'(iss_valid), int'(r1));
                    nxt(); #1;
                    check("R4", "after src1 wake", int'(iss_valid), int'(!r1));
                    check("R4", "rob", int'(iss_rob), b * 3 + w);
                end
                nxt(); expect_none("R5");
            end
        end

        // R8 / R5: fill, refuse, then drain in dispatch order
        for (int n = 0; n < 4; n++) begin
            nxt(); disp(n, 7, 7, 3, 0);
        end
        nxt(); #1;
        check("R8", "full", int'(full), 1);
        disp(9, 1, 1, 0, 0);
        nxt(); wake(7);
        expect_none("R8");
        for (int n = 0; n < 4; n++) begin
            nxt(); expect_issue("R5", n, 0);
            if (n == 0) check("R8", "full while draining", int'(full), 1);
        end
        nxt(); expect_none("R8");

        // R5: a reused slot is younger than older survivors
        nxt(); disp(0, 7, 7, 3, 0);
        nxt(); disp(1, 8, 8, 3, 0);
        nxt(); disp(2, 7, 7, 3, 0);
        nxt(); wake(8);
        nxt(); expect_issue("R5", 1, 0);
        nxt(); disp(3, 7, 7, 3, 0);
        nxt(); wake(7);
        nxt(); expect_issue("R5", 0, 0);
        nxt(); expect_issue("R5", 2, 0);
        nxt(); expect_issue("R5", 3, 0);
        nxt(); expect_none("R5");

        // R6 / R7: each branch tag, each outcome, every mask value
        for (int k = 0; k < BR_N; k++) begin
            for (int m = 0; m < 2; m++) begin
                string rq;
                rq = (m == 1) ? "R7" : "R6";
                for (int r = 0; r < 4; r++) begin
                    nxt(); disp(r, 9, 9, 3, r);
                end
                nxt(); br_valid = 1; br_bad = m[0]; br_idx = BIDX_W'(k);
                nxt(); wake(9); #1;
                check(rq, "full after outcome", int'(full), (m == 1) ? 0 : 1);
                for (int r = 0; r < 4; r++) begin
                    if (!(m == 1 && r[k])) begin
                        nxt(); expect_issue(rq, r, r & ~(1 << k));
                    end
                end
                nxt(); expect_none(rq);
            end
        end

        // R7: same-cycle dispatch with the killed bit is dropped
        nxt(); disp(5, 1, 1, 0, 1);
        br_valid = 1; br_bad = 1; br_idx = 0;
        nxt(); expect_none("R7");
        // R7: ready entry hit by mispredict is not issued in that cycle
        nxt(); disp(6, 1, 1, 0, 2);
        nxt(); br_valid = 1; br_bad = 1; br_idx = 1;
        expect_none("R7");
        nxt(); expect_none("R7");
        // R6: issue in the confirm cycle shows the bit cleared
        nxt(); disp(7, 1, 1, 0, 3);
        nxt(); br_valid = 1; br_bad = 0; br_idx = 0;
        expect_issue("R6", 7, 2);
        nxt(); expect_none("R6");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule